// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block times the serial clock of an I2C master. A sequencer asks it to open a transfer with `start_req`. The block first holds SDA low with SCL released for the start-hold interval. It then alternates low and high SCL phases until the sequencer asks for a stop. After that request, the block closes the bus with a stop condition.

Two pairs of count inputs set the phase lengths: one pair for standard mode and one pair for fast mode. `fast_sel` picks the pair. All timing is counted in input clock cycles.

The low phase begins the moment the block pulls SCL low. The high phase has a fixed overhead on top of its programmed count. Its counter does not run until the sampled line is seen high, so a slave that holds SCL low stretches the phase.

Two one-cycle strobes mark each falling edge and each observed rising edge. The data path uses them to shift data out and to sample data in.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, SCL and SDA are released, both strobes are 0 and `busy` is 0.
- R2: When `start_req` is high in an idle cycle, `sda_pull_low` rises in the next cycle while SCL stays released. SCL is pulled low exactly high-count + 3 cycles after SDA went low.
- R3: Each low phase keeps `scl_pull_low` at 1 for exactly low-count + 1 cycles.
- R4: With no slave holding the line, each high phase between two low phases keeps SCL released for exactly high-count + 8 cycles.
- R5: Every cycle in which the released SCL is still sampled low lengthens the high phase by one cycle. The high count runs only after SCL is seen high.
- R6: `fast_sel` = 1 takes both counts from the fast pair, and `fast_sel` = 0 takes them from the standard pair.
- R7: A count is taken at the start of the phase that uses it. Changing a count input during a phase leaves that phase unchanged, and the next phase of that kind uses the new value.
- R8: A `stop_req` seen during a transfer makes the block drive SDA low from the next cycle until the current low phase ends, then release SCL with SDA still low. SDA stays low for max(high-count, 1) + 1 cycles, counted from the first cycle SCL is sampled high. When SDA is released, `busy` drops.
- R9: `fall_stb` is 1 exactly in the first cycle of each low phase. `rise_stb` is 1 exactly once per release, in the first cycle the released SCL is sampled high.
- R10: `start_req` while `busy` is 1 is ignored: phase lengths are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| std_high_cnt | input | CW | Standard-mode high count |
| std_low_cnt | input | CW | Standard-mode low count |
| fast_high_cnt | input | CW | Fast-mode high count |
| fast_low_cnt | input | CW | Fast-mode low count |
| fast_sel | input | 1 | 1 selects the fast pair |
| start_req | input | 1 | Open a transfer (taken only when idle) |
| stop_req | input | 1 | Close the transfer after the current low phase |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | Pull-down enable for SCL |
| sda_pull_low | output | 1 | Pull-down enable for SDA during start and stop |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle SCL is seen high after release |
| busy | output | 1 | Transfer in progress |

## Verification
A phase counter loaded with a wrong value, or a count that slips, shows as a phase that is too long or too short. The error appears at the end of that same phase, as an early or late edge on `scl_pull_low`. A wrong state shows one cycle after the faulty transition, as a wrong level on `scl_pull_low` or `sda_pull_low`, a missing or doubled strobe, or `busy` dropping at the wrong time. The bench therefore measures every phase edge to the exact cycle. It does so in both modes, with a stretching slave, with counts that change mid-phase, and for a stop with a zero high count.

// File: rtl/i2c_scl_pkg.sv
// Package: phase encoding and fixed latencies of the SCL phase timer.
// Assumes: every count is in input clock cycles.
package i2c_scl_pkg;

    // Fixed cycles added to the programmed counts.
    localparam int START_EXTRA = 3;  // start hold = high count + 3
    localparam int LOW_EXTRA   = 1;  // low phase = low count + 1
    localparam int HIGH_EXTRA  = 8;  // high phase = high count + 8
    localparam int SAMPLE_CYC  = 1;  // cycle spent seeing the released line high

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_LOW   = 3'd2,
        PH_HWAIT = 3'd3,
        PH_HIGH  = 3'd4,
        PH_SWAIT = 3'd5,
        PH_SHOLD = 3'd6
    } phase_t;

endpackage

// File: rtl/i2c_scl_sel.sv
// Count selector: picks the standard or fast pair and turns it into
// counter load values for each kind of phase.
// Assumes: a counter loaded with value V runs V + 1 cycles.
module i2c_scl_sel #(
    parameter int CW = 16,
    parameter int PW = CW + 1
) (
    input  logic [CW-1:0] std_high_cnt,
    input  logic [CW-1:0] std_low_cnt,
    input  logic [CW-1:0] fast_high_cnt,
    input  logic [CW-1:0] fast_low_cnt,
    input  logic          fast_sel,
    output logic [PW-1:0] ld_start,
    output logic [PW-1:0] ld_low,
    output logic [PW-1:0] ld_high,
    output logic [PW-1:0] ld_stop
);
    import i2c_scl_pkg::*;

    localparam int NMODE = 2;

    logic [CW-1:0] hi_tab [NMODE];
    logic [CW-1:0] lo_tab [NMODE];
    logic [CW-1:0] hi_sel;
    logic [CW-1:0] lo_sel;

    // One table entry per speed mode.
    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        if (m == 0) begin : g_std
            assign hi_tab[m] = std_high_cnt;
            assign lo_tab[m] = std_low_cnt;
        end else begin : g_fast
            assign hi_tab[m] = fast_high_cnt;
            assign lo_tab[m] = fast_low_cnt;
        end
    end

    // Pick the active pair.
    always_comb begin
        hi_sel = hi_tab[fast_sel];
        lo_sel = lo_tab[fast_sel];
    end

    // Load values: total length minus the one cycle the counter adds.
    always_comb begin
        ld_start = PW'(hi_sel) + PW'(START_EXTRA - 1);
        ld_low   = PW'(lo_sel) + PW'(LOW_EXTRA - 1);
        ld_high  = PW'(hi_sel) + PW'(HIGH_EXTRA - SAMPLE_CYC - 1);
        ld_stop  = (hi_sel == '0) ? '0 : PW'(hi_sel) - PW'(1);
    end

endmodule

// File: rtl/i2c_scl_cnt.sv
// Phase down-counter: loads a value, then counts down to zero and holds there.
// A load of V gives done V cycles later, so a phase lasts V + 1 cycles.
// Assumes: the sequencer loads on the cycle it leaves the previous phase.
module i2c_scl_cnt #(
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic          done
);
    logic [PW-1:0] cnt_q;

    // Load, count down, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - PW'(1);
    end

    assign done = (cnt_q == '0);

    // R3: with no new load, an expired counter stays expired.
    assert_cnt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

    // R3: with no load, the counter only moves toward zero.
    assert_cnt_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(done)) |-> (cnt_q == $past(cnt_q) - PW'(1)));

endmodule

// File: rtl/i2c_scl_fsm.sv
// Phase sequencer: steps through start hold, low, high wait, high and stop,
// loads the phase counter and drives the line enables and strobes.
// Assumes: scl_in is already synchronised to clk.
module i2c_scl_fsm #(
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          scl_in,
    input  logic          done,
    input  logic [PW-1:0] ld_start,
    input  logic [PW-1:0] ld_low,
    input  logic [PW-1:0] ld_high,
    input  logic [PW-1:0] ld_stop,
    output logic          load,
    output logic [PW-1:0] load_val,
    output logic          scl_pull_low,
    output logic          sda_pull_low,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          busy
);
    import i2c_scl_pkg::*;

    phase_t state_q, state_d;
    logic   stop_pend_q;
    logic   fall_q;
    logic   stop_now;

    assign stop_now = stop_pend_q | stop_req;

    // Next phase and counter load.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            PH_IDLE: if (start_req) begin
                state_d = PH_START; load = 1'b1; load_val = ld_start;
            end
            PH_START: if (done) begin
                state_d = PH_LOW; load = 1'b1; load_val = ld_low;
            end
            PH_LOW: if (done) begin
                state_d = stop_now ? PH_SWAIT : PH_HWAIT;
            end
            PH_HWAIT: if (scl_in) begin
                state_d = PH_HIGH; load = 1'b1; load_val = ld_high;
            end
            PH_HIGH: if (done) begin
                state_d = PH_LOW; load = 1'b1; load_val = ld_low;
            end
            PH_SWAIT: if (scl_in) begin
                state_d = PH_SHOLD; load = 1'b1; load_val = ld_stop;
            end
            PH_SHOLD: if (done) begin
                state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Remember a stop request until the bus is closing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_pend_q <= 1'b0;
        else if (state_q == PH_IDLE || state_q == PH_SWAIT || state_q == PH_SHOLD)
            stop_pend_q <= 1'b0;
        else if (stop_req)
            stop_pend_q <= 1'b1;
    end

    // Flag the first cycle of each low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= (state_d == PH_LOW) && (state_q != PH_LOW);
    end

    assign scl_pull_low = (state_q == PH_LOW);
    assign sda_pull_low = (state_q == PH_START) || (state_q == PH_SWAIT) ||
                          (state_q == PH_SHOLD) || (state_q == PH_LOW && stop_pend_q);
    assign fall_stb     = fall_q;
    assign rise_stb     = ((state_q == PH_HWAIT) || (state_q == PH_SWAIT)) && scl_in;
    assign busy         = (state_q != PH_IDLE);

    // R5: the high count starts only after the line was seen high.
    assert_high_after_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH && $past(state_q) != PH_HIGH) |-> $past(scl_in));

    // R10: a transfer opens only from idle on a start request.
    assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_START && $past(state_q) != PH_START) |->
            ($past(state_q) == PH_IDLE && $past(start_req)));

    // R9: strobes never coincide, and every low phase opens with a fall strobe.
    assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));
    assert_fall_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_low && !$past(scl_pull_low)) |-> fall_stb);

    // R8: the bus goes idle only after the stop hold count expired.
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && $past(state_q) == PH_SHOLD) |-> $past(done));

endmodule

// File: rtl/i2c_scl_timer.sv
// SCL phase timer top: joins the count selector, the phase counter and the
// phase sequencer.
// Assumes: the count inputs are static or change only as a whole.
module i2c_scl_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] std_high_cnt,
    input  logic [CW-1:0] std_low_cnt,
    input  logic [CW-1:0] fast_high_cnt,
    input  logic [CW-1:0] fast_low_cnt,
    input  logic          fast_sel,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          scl_in,
    output logic          scl_pull_low,
    output logic          sda_pull_low,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          busy
);
    localparam int PW = CW + 1;

    logic [PW-1:0] ld_start, ld_low, ld_high, ld_stop, load_val;
    logic          load, done;

    i2c_scl_sel #(.CW(CW), .PW(PW)) u_sel (
        .std_high_cnt (std_high_cnt),
        .std_low_cnt  (std_low_cnt),
        .fast_high_cnt(fast_high_cnt),
        .fast_low_cnt (fast_low_cnt),
        .fast_sel     (fast_sel),
        .ld_start     (ld_start),
        .ld_low       (ld_low),
        .ld_high      (ld_high),
        .ld_stop      (ld_stop)
    );

    i2c_scl_cnt #(.PW(PW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .done    (done)
    );

    i2c_scl_fsm #(.PW(PW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .scl_in      (scl_in),
        .done        (done),
        .ld_start    (ld_start),
        .ld_low      (ld_low),
        .ld_high     (ld_high),
        .ld_stop     (ld_stop),
        .load        (load),
        .load_val    (load_val),
        .scl_pull_low(scl_pull_low),
        .sda_pull_low(sda_pull_low),
        .fall_stb    (fall_stb),
        .rise_stb    (rise_stb),
        .busy        (busy)
    );

    // R1: nothing is driven on the bus while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull_low && !sda_pull_low));

endmodule

// File: tb/sim_i2c_scl_timer.sv
// Directed bench for the SCL phase timer; the SCL line is modelled as
// open-drain with an optional slave hold.
module sim_i2c_scl_timer;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] std_high_cnt = 16'd5, std_low_cnt = 16'd7;
    logic [CW-1:0] fast_high_cnt = 16'd2, fast_low_cnt = 16'd3;
    logic          fast_sel = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic          slave_hold = 1'b0;
    logic          scl_in;
    logic          scl_pull_low, sda_pull_low, fall_stb, rise_stb, busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign scl_in = ~(scl_pull_low | slave_hold);

    i2c_scl_timer #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .std_high_cnt(std_high_cnt), .std_low_cnt(std_low_cnt),
        .fast_high_cnt(fast_high_cnt), .fast_low_cnt(fast_low_cnt),
        .fast_sel(fast_sel), .start_req(start_req), .stop_req(stop_req),
        .scl_in(scl_in), .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
        .fall_stb(fall_stb), .rise_stb(rise_stb), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Open a transfer and measure the start hold; ends on the first low cycle.
    task automatic start_xfer(input string req, input int exp);
        int n = 0;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check({req, " sda low at start"}, int'(sda_pull_low), 1);
        check({req, " busy at start"}, int'(busy), 1);
        while (!scl_pull_low) begin n++; @(negedge clk); end
        check({req, " start hold"}, n, exp);
    endtask

    // Measure a low phase; poke 1 pulses stop, 2 pulses start; newlo>=0 rewrites.
    task automatic meas_low(input string req, input int exp, input int poke, input int newlo);
        int n = 0;
        int last_sda = 0;
        check("R9 fall strobe", int'(fall_stb), 1);
        while (scl_pull_low) begin
            n++;
            if (n == 1) begin
                if (poke == 1) stop_req = 1'b1;
                if (poke == 2) start_req = 1'b1;
                if (newlo >= 0) std_low_cnt = CW'(newlo);
            end else begin
                stop_req = 1'b0;
                start_req = 1'b0;
            end
            last_sda = int'(sda_pull_low);
            @(negedge clk);
        end
        stop_req = 1'b0;
        start_req = 1'b0;
        check({req, " low length"}, n, exp);
        if (poke == 1) check("R8 sda low before stop", last_sda, 1);
    endtask

    // Measure a high phase with a slave holding the line for `stretch` cycles.
    task automatic meas_high(input string req, input int exp, input int stretch, input int newhi);
        int n = 0;
        int rises = 0;
        while (!scl_pull_low) begin
            if (n == 0 && stretch > 0) slave_hold = 1'b1;
            if (n == stretch) slave_hold = 1'b0;
            if (n == 1 && newhi >= 0) std_high_cnt = CW'(newhi);
            rises += int'(rise_stb);
            n++;
            @(negedge clk);
        end
        check({req, " high length"}, n, exp);
        check("R9 one rise strobe", rises, 1);
    endtask

    // Measure the stop hold; starts on the first released cycle.
    task automatic meas_stop(input int exp);
        int n = 0;
        while (sda_pull_low && busy) begin
            if (scl_pull_low) check("R8 scl released in stop", 1, 0);
            n++;
            @(negedge clk);
        end
        check("R8 stop hold", n, exp);
        check("R8 idle after stop", int'(busy), 0);
        check("R8 sda released", int'(sda_pull_low), 0);
    endtask

    task automatic t_reset;
        check("R1 scl", int'(scl_pull_low), 0);
        check("R1 sda", int'(sda_pull_low), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 strobes", int'(fall_stb | rise_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
    endtask

    // Standard mode, hi=5 lo=7.
    task automatic t_std;
        fast_sel = 1'b0;
        start_xfer("R2", 8);
        meas_low("R3", 8, 0, -1);
        meas_high("R4", 13, 0, -1);
        meas_low("R3", 8, 0, -1);
        meas_high("R4", 13, 0, -1);
        meas_low("R8", 8, 1, -1);
        meas_stop(6);
    endtask

    // Fast mode, hi=2 lo=3.
    task automatic t_fast;
        fast_sel = 1'b1;
        start_xfer("R6", 5);
        meas_low("R6", 4, 0, -1);
        meas_high("R6", 10, 0, -1);
        meas_low("R6", 4, 1, -1);
        meas_stop(3);
        fast_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_stretch;
        start_xfer("R5", 8);
        meas_low("R5", 8, 0, -1);
        meas_high("R5", 17, 4, -1);
        meas_low("R5", 8, 0, -1);
        meas_high("R5", 14, 1, -1);
        meas_low("R5", 8, 1, -1);
        meas_stop(6);
    endtask

    task automatic t_midchange;
        start_xfer("R7", 8);
        meas_low("R7", 8, 0, 20);
        meas_high("R7", 13, 0, 1);
        meas_low("R7", 21, 0, -1);
        meas_high("R7", 9, 0, -1);
        meas_low("R7", 21, 1, -1);
        meas_stop(2);
        std_high_cnt = 16'd5;
        std_low_cnt = 16'd7;
        @(negedge clk);
    endtask

    task automatic t_busy_start;
        start_xfer("R10", 8);
        meas_low("R10", 8, 2, -1);
        meas_high("R10", 13, 0, -1);
        meas_low("R10", 8, 1, -1);
        meas_stop(6);
    endtask

    task automatic t_stop_zero;
        std_high_cnt = 16'd0;
        std_low_cnt = 16'd2;
        start_xfer("R2", 3);
        meas_low("R8", 3, 1, -1);
        meas_stop(2);
        std_high_cnt = 16'd5;
        std_low_cnt = 16'd7;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_std;
        t_fast;
        t_stretch;
        t_midchange;
        t_busy_start;
        t_stop_zero;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL all: watchdog actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule